// File: doc/BRIEF.md
# Write-Only SMBus Configuration Register Sink

This block is a receive-only slave on a two-wire SMBus/I2C bus. It loads a small bank of 8-bit configuration registers. A faster system clock samples the SCL and SDA lines. The block finds START and STOP conditions on those samples and checks the first byte after a START against a fixed 7-bit device address with the write direction. It acknowledges each accepted byte by pulling SDA low through an open-drain enable.

The host always opens with two bytes: a command code and a byte count. The slave acknowledges both and discards them, and neither affects which register is written. Every later byte goes into the next register in turn, starting at register 0. The host may stop after any complete byte. The whole bank is always visible as one flat parallel output, and the rest of the chip reads its configuration from there. Reading back over the bus is not supported.

Top module: `cfg_smbus_sink`

## Requirements
- R1: After reset the six registers hold 06h, FFh, FEh, 06h, 07h and 00h for registers 0 to 5. Register i appears on `cfg_regs[8*i +: 8]`, and `sda_oe` is 0.
- R2: The address byte D2h (7-bit address 69h, R/W bit 0, sent MSB first) is acknowledged. During an acknowledge the slave holds `sda_oe` at 1 for the whole ninth clock.
- R3: The command-code byte and the byte-count byte that follow the address are both acknowledged. Neither of them changes any register.
- R4: Each data byte after the byte count is stored in the next register, starting at register 0 and going up. Each data byte is acknowledged.
- R5: A STOP after any complete byte ends the transfer. Registers not written in that transfer keep their earlier values, and `sda_oe` is 0 after the STOP.
- R6: An address byte with R/W=1, or with any other address, is not acknowledged. The slave then acknowledges nothing and changes no register until the next START.
- R7: Data bytes after the last register are acknowledged and discarded.
- R8: A repeated START in the middle of a transfer restarts address matching, and the next data byte goes to register 0 again.
- R9: A data byte is committed only when its acknowledge clock ends. A byte cut short by a STOP is dropped.
- R10: `sda_oe` only ever pulls the line low. It rises and falls only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| cfg_regs | output | NREG*8 | Register bank, register i on bits 8*i+7..8*i |

## Verification
The bench aims at the byte position.
- If the command code or byte count were written into a register, register 0 would take the command value.
- A repeated START that does not clear the position would send the next data byte to register 1.
- A slave that matched only the 7-bit address would acknowledge the read address D3h.
- Extra bytes handled wrongly would either be refused an acknowledge or wrap around and overwrite register 0.
- A design that committed on the eighth bit would keep half a byte when a STOP arrives mid-byte.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SHIFT = 2'd1,
    PH_ACK   = 2'd2,
    PH_SKIP  = 2'd3
  } phase_t;

  // Number of discarded header bytes after the address (command, count).
  localparam int unsigned HDR_BYTES = 2;

  function automatic logic [7:0] default_byte(input int unsigned idx);
    case (idx)
      0:       default_byte = 8'h06;
      1:       default_byte = 8'hFF;
      2:       default_byte = 8'hFE;
      3:       default_byte = 8'h06;
      4:       default_byte = 8'h07;
      default: default_byte = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cfgbus_line_sync.sv
module cfgbus_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], raw_i};
  end

  // Idle bus level is high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = sync_q[STAGES-1] & ~last_q;
  assign fall_o  = ~sync_q[STAGES-1] & last_q;

endmodule

// File: rtl/cfgbus_engine.sv
module cfgbus_engine
  import cfgbus_pkg::*;
#(
  parameter logic [6:0]  ADDR7 = 7'h69,
  parameter int unsigned NREG  = 6,
  localparam int unsigned POS_W = $clog2(NREG + HDR_BYTES + 2),
  localparam int unsigned IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_lvl,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic [POS_W-1:0] byte_pos
);

  localparam logic [POS_W-1:0] FIRST_DATA = POS_W'(HDR_BYTES + 1);
  localparam logic [POS_W-1:0] POS_CAP    = POS_W'(HDR_BYTES + 1 + NREG);
  localparam logic [7:0]       WR_ADDR    = {ADDR7, 1'b0};

  phase_t           phase_q, phase_d;
  logic [3:0]       bitcnt_q, bitcnt_d;
  logic [7:0]       shreg_q, shreg_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic             oe_q, oe_d;
  logic             ack_done;
  logic [POS_W-1:0] data_off;

  assign ack_done = (phase_q == PH_ACK) && scl_fall && !start_det && !stop_det;
  assign data_off = pos_q - FIRST_DATA;

  always_comb begin
    phase_d  = phase_q;
    bitcnt_d = bitcnt_q;
    shreg_d  = shreg_q;
    pos_d    = pos_q;
    oe_d     = oe_q;
    if (start_det) begin
      phase_d  = PH_SHIFT;
      bitcnt_d = '0;
      pos_d    = '0;
      oe_d     = 1'b0;
    end else if (stop_det) begin
      phase_d = PH_IDLE;
      oe_d    = 1'b0;
    end else begin
      case (phase_q)
        PH_SHIFT: begin
          if (scl_rise && (bitcnt_q != 4'd8)) begin
            shreg_d  = {shreg_q[6:0], sda_lvl};
            bitcnt_d = bitcnt_q + 4'd1;
          end else if (scl_fall && (bitcnt_q == 4'd8)) begin
            if ((pos_q == '0) && (shreg_q != WR_ADDR)) begin
              phase_d = PH_SKIP;
            end else begin
              phase_d = PH_ACK;
              oe_d    = 1'b1;
            end
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            oe_d     = 1'b0;
            phase_d  = PH_SHIFT;
            bitcnt_d = '0;
            if (pos_q != POS_CAP) pos_d = pos_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      pos_q    <= '0;
      oe_q     <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      bitcnt_q <= bitcnt_d;
      shreg_q  <= shreg_d;
      pos_q    <= pos_d;
      oe_q     <= oe_d;
    end
  end

  assign wr_en    = ack_done && (pos_q >= FIRST_DATA) && (pos_q < POS_CAP);
  assign wr_idx   = data_off[IDX_W-1:0];
  assign wr_data  = shreg_q;
  assign sda_oe   = oe_q;
  assign byte_pos = pos_q;

endmodule

// File: rtl/cfgbus_regs.sv
module cfgbus_regs
  import cfgbus_pkg::*;
#(
  parameter int unsigned NREG = 6,
  localparam int unsigned IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [7:0]        wr_data,
  output logic [NREG*8-1:0] regs_o
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [7:0] val_q;
    logic       hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= default_byte(g);
      end else if (hit) begin
        val_q <= wr_data;
      end
    end
    assign regs_o[8*g +: 8] = val_q;
  end

endmodule

// File: rtl/cfg_smbus_sink.sv
module cfg_smbus_sink
  import cfgbus_pkg::*;
#(
  parameter logic [6:0]  ADDR7       = 7'h69,
  parameter int unsigned NREG        = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] cfg_regs
);

  localparam int unsigned POS_W = $clog2(NREG + HDR_BYTES + 2);
  localparam int unsigned IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic             scl_lvl, scl_rise, scl_fall;
  logic             sda_lvl, sda_rise, sda_fall;
  logic             start_det, stop_det;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data;
  logic [POS_W-1:0] byte_pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  cfgbus_line_sync #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst_n(rst_sync_n), .raw_i(scl_i),
    .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  cfgbus_line_sync #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst_n(rst_sync_n), .raw_i(sda_i),
    .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  assign start_det = scl_lvl & sda_fall;
  assign stop_det  = scl_lvl & sda_rise;

  cfgbus_engine #(.ADDR7(ADDR7), .NREG(NREG)) u_eng (
    .clk(clk), .rst_n(rst_sync_n), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .byte_pos(byte_pos)
  );

  cfgbus_regs #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .regs_o(cfg_regs)
  );

endmodule

// File: rtl/cfgbus_checker.sv
module cfgbus_checker #(
  parameter int unsigned NREG  = 6,
  parameter int unsigned POS_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe,
  input logic [NREG*8-1:0] cfg_regs,
  input logic              scl_s,
  input logic              start_det,
  input logic              stop_det,
  input logic [POS_W-1:0]  byte_pos
);

  assert_oe_rise_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  assert_oe_fall_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_s);

  assert_commit_at_ack_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_regs) |-> $fell(sda_oe));

  assert_stop_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  assert_start_clears_pos_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (byte_pos == '0));

  assert_pos_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_pos <= POS_W'(NREG + 3));

endmodule

bind cfg_smbus_sink cfgbus_checker #(.NREG(NREG), .POS_W(POS_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .sda_oe(sda_oe), .cfg_regs(cfg_regs),
  .scl_s(scl_lvl), .start_det(start_det), .stop_det(stop_det),
  .byte_pos(byte_pos)
);

// File: tb/tb_cfg_smbus_sink.sv
module tb_cfg_smbus_sink;

  localparam int NREG = 6;
  localparam int Q    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_scl = 1'b1;
  logic host_sda = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] cfg_regs;
  wire  sda_line = host_sda & ~sda_oe;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [7:0] exp_r [NREG];

  always #10 clk = ~clk;

  cfg_smbus_sink #(.NREG(NREG)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .cfg_regs(cfg_regs)
  );

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_regs(input string tag);
    for (int i = 0; i < NREG; i++) check(tag, {24'h0, cfg_regs[8*i +: 8]}, {24'h0, exp_r[i]});
  endtask

  task automatic bus_start();
    host_sda = 1'b1; host_scl = 1'b1; wq();
    host_sda = 1'b0; wq();
    host_scl = 1'b0; wq();
  endtask

  task automatic bus_rstart();
    host_sda = 1'b1; wq();
    host_scl = 1'b1; wq();
    host_sda = 1'b0; wq();
    host_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; wq();
    host_scl = 1'b1; wq();
    host_sda = 1'b1; wq(); wq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      host_sda = b[i]; wq();
      host_scl = 1'b1; wq(); wq();
      host_scl = 1'b0; wq();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    send_bits(b, 8);
    host_sda = 1'b1; wq();
    host_scl = 1'b1; wq();
    acked = ~sda_line;
    wq();
    host_scl = 1'b0; wq();
  endtask

  task automatic header(input string tag);
    logic a;
    send_byte(8'hD2, a); check({tag, " R2 addr ack"}, {31'h0, a}, 32'h1);
    send_byte(8'h03, a); check({tag, " R3 cmd ack"}, {31'h0, a}, 32'h1);
    send_byte(8'h05, a); check({tag, " R3 count ack"}, {31'h0, a}, 32'h1);
  endtask

  task automatic t_reset();
    exp_r[0] = 8'h06; exp_r[1] = 8'hFF; exp_r[2] = 8'hFE;
    exp_r[3] = 8'h06; exp_r[4] = 8'h07; exp_r[5] = 8'h00;
    check_regs("R1 defaults");
    check("R1 oe idle", {31'h0, sda_oe}, 32'h0);
  endtask

  task automatic t_header_only();
    bus_start();
    header("hdr");
    bus_stop();
    check_regs("R3 header discarded");
  endtask

  task automatic t_full_write();
    logic a;
    bus_start();
    header("full");
    for (int i = 0; i < NREG; i++) begin
      send_byte(8'hA0 + 8'(i), a);
      check("R4 data ack", {31'h0, a}, 32'h1);
      exp_r[i] = 8'hA0 + 8'(i);
    end
    bus_stop();
    check_regs("R4 sequential load");
  endtask

  task automatic t_short();
    logic a;
    bus_start();
    header("short");
    send_byte(8'h5A, a); exp_r[0] = 8'h5A;
    send_byte(8'hC3, a); exp_r[1] = 8'hC3;
    bus_stop();
    check_regs("R5 short write keeps rest");
    check("R5 oe after stop", {31'h0, sda_oe}, 32'h0);
  endtask

  task automatic t_bad_addr();
    logic a;
    bus_start();
    send_byte(8'hD3, a); check("R6 read addr nack", {31'h0, a}, 32'h0);
    send_byte(8'h00, a); check("R6 ignored byte nack", {31'h0, a}, 32'h0);
    send_byte(8'h11, a); check("R6 ignored byte nack", {31'h0, a}, 32'h0);
    send_byte(8'h99, a); check("R6 ignored byte nack", {31'h0, a}, 32'h0);
    bus_stop();
    bus_start();
    send_byte(8'hD0, a); check("R6 other addr nack", {31'h0, a}, 32'h0);
    send_byte(8'h44, a); check("R6 ignored byte nack", {31'h0, a}, 32'h0);
    bus_stop();
    check_regs("R6 regs unchanged");
  endtask

  task automatic t_overflow();
    logic a;
    bus_start();
    header("ovf");
    for (int i = 0; i < NREG + 3; i++) begin
      send_byte(8'h30 + 8'(i), a);
      check("R7 ack incl. extra", {31'h0, a}, 32'h1);
      if (i < NREG) exp_r[i] = 8'h30 + 8'(i);
    end
    bus_stop();
    check_regs("R7 extra discarded");
  endtask

  task automatic t_rstart();
    logic a;
    bus_start();
    header("rs1");
    send_byte(8'h11, a); exp_r[0] = 8'h11;
    bus_rstart();
    header("rs2");
    send_byte(8'h22, a); exp_r[0] = 8'h22;
    send_byte(8'h33, a); exp_r[1] = 8'h33;
    bus_rstart();
    send_byte(8'hD3, a); check("R8 rstart rematch nack", {31'h0, a}, 32'h0);
    bus_stop();
    check_regs("R8 position reset");
  endtask

  task automatic t_partial();
    logic a;
    bus_start();
    header("part");
    send_byte(8'h77, a); exp_r[0] = 8'h77;
    send_bits(8'hFF, 4);
    bus_stop();
    check_regs("R9 partial dropped");
    check("R9 oe released", {31'h0, sda_oe}, 32'h0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_header_only();
    t_full_write();
    t_short();
    t_bad_addr();
    t_overflow();
    t_rstart();
    t_partial();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule